// File: doc/BRIEF.md
# Count/Compare Interval Timer

This block is a free-running interval timer built from a counter and a compare register. The counter advances by one on each cycle that the clock-enable tick is high. When the new counter value is equal to the compare value, the block raises a timer request on one line of a small hardware-interrupt vector. That request is a level, and only a write to the compare register removes it. Software reprograms the next deadline by writing a new compare value. The running count is kept.

The block also holds a timer-interrupt status flag. The flag follows the match and clear events only while a 3-bit revision selector holds one chosen code. For every other code the flag keeps its value. A hold input freezes the counter, and while it is high no match can occur. Each register has one write port and one read port.

Top module: `count_match_timer`

## Requirements
- R1: After reset the count reads 1, the compare reads 0, the request is low, the status flag is 0 and every interrupt line is 0.
- R2: On a clock edge with `tick_en` high, `cnt_hold` low and no write, the count increases by one. After the all-ones value it goes to 0 and raises no flag.
- R3: A write with `wr_sel`=0 loads `wr_data` into the count and leaves the compare unchanged.
- R4: A write with `wr_sel`=1 loads `wr_data` into the compare. It leaves the count at its current value and drops the timer request.
- R5: While `cnt_hold` is 1 the count does not change and no match is detected, even when `tick_en` is high.
- R6: When an advance produces a count equal to the compare, the request goes high on that same edge. It then stays high until a compare write, and later matches change nothing.
- R7: When `rev_sel` equals 1, `ti_flag` is set by a match and cleared by a compare write. For any other `rev_sel` value, `ti_flag` keeps its value.
- R8: The request appears on bit 7 of the 8-bit `irq_lines` vector, and all the other bits stay 0.
- R9: If a write leaves the count equal to the compare, no match follows at once. The next match comes after a full wrap of 2^width advances.
- R10: A register write and a tick in the same cycle cause no advance and no match. Only the write takes effect.
- R11: `rd_data` shows the count when `rd_sel`=0 and the compare when `rd_sel`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count-enable tick |
| cnt_hold | input | 1 | Freeze counter and matching |
| rev_sel | input | REV_W (3) | Revision selector gating the status flag |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 count, 1 compare |
| wr_data | input | CNT_W (32) | Write data |
| rd_sel | input | 1 | Read source: 0 count, 1 compare |
| rd_data | output | CNT_W (32) | Read data |
| irq_lines | output | IRQ_LINES (8) | Interrupt line vector, timer on index IRQ_IDX (7) |
| ti_flag | output | 1 | Timer-interrupt status flag |

## Verification
The bench builds the timer with an 8-bit counter and keeps the other parameters at their defaults. At that width a full wrap is 256 ticks. This brings the all-ones-to-zero rollover and the full-period wait after an equal-value write within a short directed run. The defaults keep the timer request on line 7 of 8, so the line position is checked exactly as it is shipped.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic {
        SEL_COUNT = 1'b0,
        SEL_CMP   = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/tmr_step.sv
module tmr_step #(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] count_q,
    input  logic [CNT_W-1:0] cmp_q,
    input  logic             advance,
    output logic [CNT_W-1:0] count_nx,
    output logic             hit
);
    logic [CNT_W-1:0] incr;

    always_comb begin
        incr     = count_q + CNT_W'(1);
        count_nx = advance ? incr : count_q;
        hit      = advance && (incr == cmp_q);
    end
endmodule

// File: rtl/tmr_status.sv
module tmr_status #(
    parameter int REV_W     = 3,
    parameter int MATCH_REV = 1
) (
    input  logic             ti_q,
    input  logic [REV_W-1:0] rev_sel,
    input  logic             set_ev,
    input  logic             clr_ev,
    output logic             ti_d
);
    logic rev_ok;

    always_comb begin
        rev_ok = (rev_sel == REV_W'(MATCH_REV));
        ti_d   = ti_q;
        if (rev_ok) begin
            if (clr_ev)      ti_d = 1'b0;
            else if (set_ev) ti_d = 1'b1;
        end
    end
endmodule

// File: rtl/tmr_line_map.sv
module tmr_line_map #(
    parameter int IRQ_LINES = 8,
    parameter int IRQ_IDX   = 7
) (
    input  logic                 req,
    output logic [IRQ_LINES-1:0] lines
);
    for (genvar g = 0; g < IRQ_LINES; g++) begin : g_line
        if (g == IRQ_IDX) begin : g_tmr
            assign lines[g] = req;
        end else begin : g_idle
            assign lines[g] = 1'b0;
        end
    end
endmodule

// File: rtl/count_match_timer.sv
module count_match_timer #(
    parameter int CNT_W       = 32,
    parameter int REV_W       = 3,
    parameter int MATCH_REV   = 1,
    parameter int RESET_COUNT = 1,
    parameter int IRQ_LINES   = 8,
    parameter int IRQ_IDX     = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_en,
    input  logic                 cnt_hold,
    input  logic [REV_W-1:0]     rev_sel,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [CNT_W-1:0]     wr_data,
    input  logic                 rd_sel,
    output logic [CNT_W-1:0]     rd_data,
    output logic [IRQ_LINES-1:0] irq_lines,
    output logic                 ti_flag
);
    import tmr_pkg::*;

    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(RESET_COUNT);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] cmp;
        logic             irq;
        logic             ti;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    logic             wr_cnt, wr_cmp, advance, hit, ti_d;
    logic [CNT_W-1:0] count_nx;
    logic [CNT_W-1:0] count_q, cmp_q;
    logic             irq_pend;

    assign count_q  = st_q.count;
    assign cmp_q    = st_q.cmp;
    assign irq_pend = st_q.irq;

    always_comb begin
        wr_cnt  = wr_en && (reg_sel_e'(wr_sel) == SEL_COUNT);
        wr_cmp  = wr_en && (reg_sel_e'(wr_sel) == SEL_CMP);
        advance = tick_en && !cnt_hold && !wr_en;
    end

    tmr_step #(.CNT_W(CNT_W)) u_step (
        .count_q (st_q.count),
        .cmp_q   (st_q.cmp),
        .advance (advance),
        .count_nx(count_nx),
        .hit     (hit)
    );

    tmr_status #(.REV_W(REV_W), .MATCH_REV(MATCH_REV)) u_status (
        .ti_q   (st_q.ti),
        .rev_sel(rev_sel),
        .set_ev (hit),
        .clr_ev (wr_cmp),
        .ti_d   (ti_d)
    );

    tmr_line_map #(.IRQ_LINES(IRQ_LINES), .IRQ_IDX(IRQ_IDX)) u_map (
        .req  (st_q.irq),
        .lines(irq_lines)
    );

    always_comb begin
        st_d       = st_q;
        st_d.count = wr_cnt ? wr_data : count_nx;
        if (wr_cmp) begin
            st_d.cmp = wr_data;
            st_d.irq = 1'b0;
        end else if (hit) begin
            st_d.irq = 1'b1;
        end
        st_d.ti = ti_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.count <= CNT_INIT;
            st_q.cmp   <= '0;
            st_q.irq   <= 1'b0;
            st_q.ti    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = (reg_sel_e'(rd_sel) == SEL_CMP) ? st_q.cmp : st_q.count;
    assign ti_flag = st_q.ti;
endmodule

// File: rtl/tmr_checks.sv
module tmr_checks #(
    parameter int CNT_W     = 32,
    parameter int REV_W     = 3,
    parameter int MATCH_REV = 1,
    parameter int IRQ_LINES = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick_en,
    input logic                 cnt_hold,
    input logic [REV_W-1:0]     rev_sel,
    input logic                 wr_en,
    input logic                 wr_sel,
    input logic [CNT_W-1:0]     wr_data,
    input logic [CNT_W-1:0]     count_q,
    input logic [CNT_W-1:0]     cmp_q,
    input logic                 irq_pend,
    input logic [IRQ_LINES-1:0] irq_lines,
    input logic                 ti_flag
);
    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !cnt_hold && !wr_en) |=> count_q == CNT_W'($past(count_q) + CNT_W'(1)));

    p_load_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> (count_q == $past(wr_data)) && $stable(cmp_q));

    p_cmp_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> (cmp_q == $past(wr_data)) && !irq_pend && $stable(count_q));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_hold && !wr_en) |=> $stable(count_q) && !$rose(irq_pend));

    p_rise_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pend) |-> (count_q == cmp_q));

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend && !(wr_en && wr_sel)) |=> irq_pend);

    p_ti_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rev_sel != REV_W'(MATCH_REV)) |=> $stable(ti_flag));

    p_lines_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_lines));

    p_write_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tick_en) |=> !$rose(irq_pend));
endmodule

bind count_match_timer tmr_checks #(
    .CNT_W(CNT_W), .REV_W(REV_W), .MATCH_REV(MATCH_REV), .IRQ_LINES(IRQ_LINES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .cnt_hold (cnt_hold),
    .rev_sel  (rev_sel),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .count_q  (count_q),
    .cmp_q    (cmp_q),
    .irq_pend (irq_pend),
    .irq_lines(irq_lines),
    .ti_flag  (ti_flag)
);

// File: tb/sim_count_match_timer.sv
`timescale 1ns/1ps
module sim_count_match_timer;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 1'b0;
    logic         cnt_hold = 1'b0;
    logic [2:0]   rev_sel = 3'd1;
    logic         wr_en = 1'b0;
    logic         wr_sel = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rd_sel = 1'b0;
    logic [W-1:0] rd_data;
    logic [7:0]   irq_lines;
    logic         ti_flag;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    count_match_timer #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_hold(cnt_hold),
        .rev_sel(rev_sel), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .irq_lines(irq_lines), .ti_flag(ti_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic sel, output int val);
        rd_sel = sel;
        #0.5;
        val = int'(rd_data);
    endtask

    task automatic run(input int n);
        tick_en = 1'b1;
        repeat (n) @(posedge clk);
        #1;
        tick_en = 1'b0;
    endtask

    task automatic wr(input logic sel, input int data, input logic tick);
        wr_en = 1'b1; wr_sel = sel; wr_data = W'(data); tick_en = tick;
        @(posedge clk);
        #1;
        wr_en = 1'b0; tick_en = 1'b0;
    endtask

    task automatic t_reset;
        int v;
        rd(1'b0, v); chk("R1 count", v, 1);
        rd(1'b1, v); chk("R11 R1 compare", v, 0);
        chk("R1 irq lines", int'(irq_lines), 0);
        chk("R1 ti", int'(ti_flag), 0);
    endtask

    task automatic t_count_and_write;
        int v;
        run(5);
        rd(1'b0, v); chk("R2 advance", v, 6);
        wr(1'b0, 'h10, 1'b1);
        rd(1'b0, v); chk("R3 R10 count load", v, 'h10);
        rd(1'b1, v); chk("R3 compare kept", v, 0);
        wr(1'b1, 'h14, 1'b1);
        rd(1'b0, v); chk("R4 R10 count kept", v, 'h10);
        rd(1'b1, v); chk("R11 compare read", v, 'h14);
    endtask

    task automatic t_match;
        int v;
        run(3);
        chk("R6 no early match", int'(irq_lines), 0);
        run(1);
        rd(1'b0, v); chk("R6 count at match", v, 'h14);
        chk("R8 line 7", int'(irq_lines), 'h80);
        chk("R7 ti set", int'(ti_flag), 1);
        run(300);
        chk("R6 sticky", int'(irq_lines), 'h80);
    endtask

    task automatic t_rev_gate;
        int v;
        rev_sel = 3'd0;
        rd(1'b0, v);
        wr(1'b1, (v + 2) & 'hFF, 1'b0);
        chk("R4 clears irq", int'(irq_lines), 0);
        chk("R7 ti untouched on clear", int'(ti_flag), 1);
        rev_sel = 3'd1;
        wr(1'b1, (v + 2) & 'hFF, 1'b0);
        chk("R7 ti cleared", int'(ti_flag), 0);
        rev_sel = 3'd2;
        run(2);
        chk("R6 match rev2", int'(irq_lines), 'h80);
        chk("R7 ti untouched on match", int'(ti_flag), 0);
        rev_sel = 3'd1;
    endtask

    task automatic t_hold;
        int v;
        wr(1'b0, 'h20, 1'b0);
        wr(1'b1, 'h21, 1'b0);
        cnt_hold = 1'b1;
        run(6);
        rd(1'b0, v); chk("R5 frozen", v, 'h20);
        chk("R5 no match", int'(irq_lines), 0);
        cnt_hold = 1'b0;
        run(1);
        chk("R6 match after hold", int'(irq_lines), 'h80);
    endtask

    task automatic t_wrap;
        int v;
        wr(1'b1, 'h05, 1'b0);
        wr(1'b0, 'hFE, 1'b0);
        run(2);
        rd(1'b0, v); chk("R2 wrap to zero", v, 0);
        chk("R2 no flag on wrap", int'(irq_lines), 0);
    endtask

    task automatic t_equal_write;
        int v;
        wr(1'b0, 'h40, 1'b0);
        wr(1'b1, 'h40, 1'b0);
        run(1);
        chk("R9 no immediate fire", int'(irq_lines), 0);
        run(254);
        rd(1'b0, v); chk("R9 count before wrap", v, 'h3F);
        chk("R9 still quiet", int'(irq_lines), 0);
        run(1);
        chk("R9 fires after full wrap", int'(irq_lines), 'h80);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_count_and_write();
        t_match();
        t_rev_gate();
        t_hold();
        t_wrap();
        t_equal_write();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule